// File: doc/BRIEF.md
# Integer ALU with Flags

This block is the integer execution slice of a 32-bit processor datapath. Every cycle it takes two operand values, an operation code, a form select and a 5-bit short field. It returns the result of the selected operation and a write-enable for the destination register, both within the same cycle. The block keeps a four-bit condition flag register of sign, zero, overflow and carry, and updates it on the clock edge that closes a valid operation.

Operand `src_a_i` is the source operand. Operand `src_b_i` is the destination register's old value, so it is the minuend and the value that gets shifted. When `imm_form_i` is set, the short field takes the place of `src_a_i`. It is sign-extended for move, arithmetic and logical operations, and used as an unsigned count for shifts. Register access, decode, branch conditions, multiply and divide belong to other blocks.

Top module: `int_alu_flags`

## Requirements
- R1: `op_code_i` encodes 0 move, 1 add, 2 subtract, 3 compare, 4 shift left, 5 logical shift right, 6 arithmetic shift right, 7 OR, 8 AND, 9 XOR, 10 NOT. For a valid defined operation other than compare, `wr_en_o` is 1 in the same cycle. Move returns A, NOT returns ~A, and the rest return B op A.
- R2: Add returns B+A modulo 2^32. Overflow is 1 when A and B have equal signs and the result's sign differs. Carry is 1 when the unsigned result is below B. Sign and zero follow the result. `flags_o` bit 0 is zero, bit 1 is sign, bit 2 is overflow and bit 3 is carry.
- R3: Subtract returns B-A. Carry is 1 when the unsigned result exceeds B. Overflow is 1 when A and B differ in sign and the result's sign differs from B.
- R4: Compare sets the four flags exactly as subtract does, and keeps `wr_en_o` at 0.
- R5: A left shift by n>0 sets carry to bit 32-n of B.
- R6: A logical or arithmetic right shift by n>0 sets carry to bit n-1 of B. The arithmetic form fills with B's bit 31.
- R7: Only the low 5 bits of a register shift count are used. A count of 0 leaves the result unchanged and clears carry. All shifts clear overflow.
- R8: OR, AND, XOR and NOT clear overflow, set sign and zero from the result, and leave carry unchanged.
- R9: In immediate form, the 5-bit field replaces A. It is sign-extended for move, add, subtract, compare and the logical operations, and zero-extended for the three shifts.
- R10: Move writes its result and leaves all four flags unchanged.
- R11: `flags_o` changes only on an edge with `op_valid_i` at 1. A synchronous `rst` clears it to 0.
- R12: Codes 11 to 15 keep `wr_en_o` at 0 and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_code_i | input | 4 | Operation code (R1) |
| imm_form_i | input | 1 | 1 selects the short-field form |
| src_a_i | input | 32 | Source operand A |
| src_b_i | input | 32 | Destination old value B |
| imm5_i | input | 5 | Short immediate or shift count |
| result_o | output | 32 | Operation result, combinational |
| wr_en_o | output | 1 | Destination write enable, combinational |
| flags_o | output | 4 | Registered flags {carry, overflow, sign, zero} |

## Verification
`result_o` and `wr_en_o` depend only on the current inputs. The bench checks them 1 ns after it drives the inputs at the falling edge, before the next rising edge. The flags pass through exactly one register, so their new value is due just after that rising edge. The bench samples them 1 ns after it and compares them with the flag value its model computed for the operation just presented. The model keeps its own copy of the flags and updates it on the same edge, so every flag that is held (move, carry on logical operations, idle cycles, unused codes) is checked as well.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_MOVE = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_CMP  = 4'd3,
    OP_SHL  = 4'd4,
    OP_SHR  = 4'd5,
    OP_SAR  = 4'd6,
    OP_OR   = 4'd7,
    OP_AND  = 4'd8,
    OP_XOR  = 4'd9,
    OP_NOT  = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_mode_e;

  localparam int FLG_Z  = 0;
  localparam int FLG_S  = 1;
  localparam int FLG_OV = 2;
  localparam int FLG_CY = 3;
  localparam int FLG_W  = 4;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic              imm_form,
  input  logic              zero_ext,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] opnd
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  always_comb begin
    if (zero_ext) imm_ext = {{PAD_W{1'b0}}, imm_val};
    else          imm_ext = {{PAD_W{imm_val[IMM_W-1]}}, imm_val};
    opnd = imm_form ? imm_ext : reg_val;
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic              do_sub,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;

  always_comb begin
    if (do_sub) wide = {1'b0, opnd_b} - {1'b0, opnd_a};
    else        wide = {1'b0, opnd_b} + {1'b0, opnd_a};
    sum   = wide[DATA_W-1:0];
    carry = wide[DATA_W];
    if (do_sub) ovf = (opnd_b[MSB] ^ opnd_a[MSB]) & (opnd_b[MSB] ^ sum[MSB]);
    else        ovf = ~(opnd_b[MSB] ^ opnd_a[MSB]) & (opnd_b[MSB] ^ sum[MSB]);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import int_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  shift_mode_e        mode,
  input  logic [DATA_W-1:0]  value,
  input  logic [SHAMT_W-1:0] count,
  output logic [DATA_W-1:0]  res,
  output logic               carry
);
  logic [DATA_W:0] left_ext;
  logic [DATA_W:0] right_ext;

  always_comb begin
    left_ext  = {1'b0, value} << count;
    if (mode == SH_RARI) right_ext = $unsigned($signed({value, 1'b0}) >>> count);
    else                 right_ext = {value, 1'b0} >> count;
    if (mode == SH_LEFT) begin
      res   = left_ext[DATA_W-1:0];
      carry = left_ext[DATA_W];
    end else begin
      res   = right_ext[DATA_W:1];
      carry = right_ext[0];
    end
  end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic [3:0]        op_code_i,
  input  logic              imm_form_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm5_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [3:0]        flags_o
);
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int MSB     = DATA_W - 1;

  logic              is_shift, is_sub, is_logic;
  logic [DATA_W-1:0] opnd_a;
  logic [DATA_W-1:0] as_sum, sh_res;
  logic              as_cy, as_ov, sh_cy;
  shift_mode_e       sh_mode;
  logic [FLG_W-1:0]  flags_q, flags_nx;

  always_comb begin
    is_shift = (op_code_i == OP_SHL) || (op_code_i == OP_SHR) || (op_code_i == OP_SAR);
    is_sub   = (op_code_i == OP_SUB) || (op_code_i == OP_CMP);
    is_logic = (op_code_i == OP_OR) || (op_code_i == OP_AND) ||
               (op_code_i == OP_XOR) || (op_code_i == OP_NOT);
    case (op_code_i)
      OP_SHR:  sh_mode = SH_RLOG;
      OP_SAR:  sh_mode = SH_RARI;
      default: sh_mode = SH_LEFT;
    endcase
  end

  alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .imm_form (imm_form_i),
    .zero_ext (is_shift),
    .reg_val  (src_a_i),
    .imm_val  (imm5_i),
    .opnd     (opnd_a)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .do_sub (is_sub),
    .opnd_a (opnd_a),
    .opnd_b (src_b_i),
    .sum    (as_sum),
    .carry  (as_cy),
    .ovf    (as_ov)
  );

  alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .mode  (sh_mode),
    .value (src_b_i),
    .count (opnd_a[SHAMT_W-1:0]),
    .res   (sh_res),
    .carry (sh_cy)
  );

  always_comb begin
    result_o = '0;
    wr_en_o  = 1'b0;
    flags_nx = flags_q;
    case (op_code_i)
      OP_MOVE: begin
        result_o = opnd_a;
        wr_en_o  = 1'b1;
      end
      OP_ADD, OP_SUB, OP_CMP: begin
        result_o = as_sum;
        wr_en_o  = (op_code_i != OP_CMP);
        flags_nx[FLG_CY] = as_cy;
        flags_nx[FLG_OV] = as_ov;
      end
      OP_SHL, OP_SHR, OP_SAR: begin
        result_o = sh_res;
        wr_en_o  = 1'b1;
        flags_nx[FLG_CY] = sh_cy;
        flags_nx[FLG_OV] = 1'b0;
      end
      OP_OR:  begin result_o = src_b_i | opnd_a; wr_en_o = 1'b1; end
      OP_AND: begin result_o = src_b_i & opnd_a; wr_en_o = 1'b1; end
      OP_XOR: begin result_o = src_b_i ^ opnd_a; wr_en_o = 1'b1; end
      OP_NOT: begin result_o = ~opnd_a;          wr_en_o = 1'b1; end
      default: ;
    endcase
    if (is_logic) flags_nx[FLG_OV] = 1'b0;
    if (is_logic || is_shift || op_code_i == OP_ADD || is_sub) begin
      flags_nx[FLG_S] = result_o[MSB];
      flags_nx[FLG_Z] = (result_o == '0);
    end
    wr_en_o = wr_en_o & op_valid_i;
  end

  always_ff @(posedge clk) begin
    if (rst)             flags_q <= '0;
    else if (op_valid_i) flags_q <= flags_nx;
  end

  assign flags_o = flags_q;

  // R4
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_code_i == OP_CMP) |-> !wr_en_o);

  // R10
  move_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_code_i == OP_MOVE) |=> $stable(flags_o));

  // R8
  logic_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && is_logic) |=> !flags_o[FLG_OV]);

  // R8
  logic_carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && is_logic) |=> $stable(flags_o[FLG_CY]));

  // R7
  zero_count_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && is_shift && opnd_a[SHAMT_W-1:0] == '0) |=> !flags_o[FLG_CY] && !flags_o[FLG_OV]);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> $stable(flags_o));

  // R11
  reset_clear_chk: assert property (@(posedge clk) rst |=> flags_o == '0);

  // R12
  unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code_i > 4'd10) |-> !wr_en_o ##1 $stable(flags_o));
endmodule

// File: tb/sim_int_alu_flags.sv
module sim_int_alu_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid_i = 1'b0;
  logic [3:0]  op_code_i = 4'd0;
  logic        imm_form_i = 1'b0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [4:0]  imm5_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;

  int total = 0;
  int bad = 0;
  logic [3:0] mflags = 4'd0;

  always #4 clk = ~clk;

  int_alu_flags u0 (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .imm_form_i(imm_form_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .imm5_i(imm5_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural model: returns expected result, write enable and next flags
  task automatic model(input logic v, input int op, input logic imm, input logic [31:0] ra,
                       input logic [31:0] b, input logic [4:0] i5,
                       output logic [31:0] r, output logic we, output logic [3:0] nf);
    logic [31:0] a;
    int n;
    logic cy, ov, sz;
    longint s;
    cy = mflags[3]; ov = mflags[2]; sz = 1'b1;
    if (imm) a = (op >= 4 && op <= 6) ? {27'd0, i5} : {{27{i5[4]}}, i5};
    else a = ra;
    n = int'(a[4:0]);
    r = 32'd0; we = (op <= 10) && (op != 3);
    case (op)
      0: begin r = a; sz = 1'b0; end
      1: begin s = longint'(b) + longint'(a); r = s[31:0]; cy = (r < b);
               ov = (a[31] == b[31]) && (r[31] != b[31]); end
      2, 3: begin s = longint'(b) - longint'(a); r = s[31:0]; cy = (r > b);
               ov = (a[31] != b[31]) && (r[31] != b[31]); end
      4: begin r = b << n; cy = (n == 0) ? 1'b0 : b[32-n]; ov = 1'b0; end
      5: begin r = b >> n; cy = (n == 0) ? 1'b0 : b[n-1]; ov = 1'b0; end
      6: begin r = $unsigned($signed(b) >>> n); cy = (n == 0) ? 1'b0 : b[n-1]; ov = 1'b0; end
      7: begin r = b | a; ov = 1'b0; end
      8: begin r = b & a; ov = 1'b0; end
      9: begin r = b ^ a; ov = 1'b0; end
      10: begin r = ~a; ov = 1'b0; end
      default: sz = 1'b0;
    endcase
    if (op > 10) begin cy = mflags[3]; ov = mflags[2]; end
    nf = sz ? {cy, ov, r[31], (r == 32'd0)} : {cy, ov, mflags[1], mflags[0]};
    we = we && v;
    if (!v) nf = mflags;
  endtask

  task automatic step(string req, logic v, int op, logic imm, logic [31:0] a,
                      logic [31:0] b, logic [4:0] i5);
    logic [31:0] er;
    logic ew;
    logic [3:0] ef;
    @(negedge clk);
    op_valid_i = v; op_code_i = op[3:0]; imm_form_i = imm;
    src_a_i = a; src_b_i = b; imm5_i = i5;
    #1;
    model(v, op, imm, a, b, i5, er, ew, ef);
    check(req, "wr_en", wr_en_o, ew);
    if (ew) check(req, "result", result_o, er);
    @(posedge clk);
    #1;
    check(req, "flags", flags_o, ef);
    mflags = ef;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    repeat (3) @(posedge clk);
    #1;
    check("R11", "reset flags", flags_o, 4'd0);
    @(negedge clk); rst = 1'b0;
    // R2 add overflow and carry
    step("R2", 1, 1, 0, 32'h1, 32'h7FFFFFFF, 0);
    step("R2", 1, 1, 0, 32'h1, 32'hFFFFFFFF, 0);
    // R3 subtract
    step("R3", 1, 2, 0, 32'h1, 32'h80000000, 0);
    step("R3", 1, 2, 0, 32'h1, 32'h0, 0);
    // R4 compare equal, no write
    step("R4", 1, 3, 0, 32'h1234, 32'h1234, 0);
    step("R4", 1, 3, 0, 32'h5, 32'h3, 0);
    // R5 left shifts
    step("R5", 1, 4, 0, 32'h1, 32'h80000001, 0);
    step("R5", 1, 4, 0, 32'd31, 32'h00000002, 0);
    // R6 right shifts
    step("R6", 1, 5, 0, 32'd2, 32'h00000003, 0);
    step("R6", 1, 6, 0, 32'd4, 32'h80000008, 0);
    // R7 count uses low bits; zero count clears carry
    step("R7", 1, 2, 0, 32'h1, 32'h0, 0);
    step("R7", 1, 4, 0, 32'h20, 32'hDEADBEEF, 0);
    step("R7", 1, 5, 0, 32'h21, 32'h00000001, 0);
    // R8 logical ops keep carry
    step("R8", 1, 1, 0, 32'h1, 32'hFFFFFFFF, 0);
    step("R8", 1, 7, 0, 32'h80000000, 32'h1, 0);
    step("R8", 1, 8, 0, 32'h0F, 32'hF0, 0);
    step("R8", 1, 9, 0, 32'hFF, 32'hFF, 0);
    step("R8", 1, 10, 0, 32'h0, 32'h0, 0);
    // R9 immediate forms
    step("R9", 1, 1, 1, 32'h0, 32'h5, 5'h1F);
    step("R9", 1, 5, 1, 32'h0, 32'h80000000, 5'h1F);
    step("R9", 1, 0, 1, 32'h0, 32'h0, 5'h10);
    step("R9", 1, 8, 1, 32'h0, 32'hFFFF0000, 5'h10);
    // R10 move leaves flags
    step("R2", 1, 2, 0, 32'h1, 32'h80000000, 0);
    step("R10", 1, 0, 0, 32'h0, 32'h0, 0);
    // R11 idle cycle, R12 unused codes
    step("R11", 0, 1, 0, 32'h1, 32'hFFFFFFFF, 0);
    step("R12", 1, 12, 0, 32'h0, 32'h0, 0);
    step("R12", 1, 15, 1, 32'h0, 32'h0, 5'h1F);
    // R1 mixed traffic across all codes
    for (int k = 0; k < 400; k++) begin
      ra = $urandom;
      rb = $urandom;
      if (k % 7 == 0) ra = rb;
      step("R1", ($urandom % 8) != 0, int'($urandom % 16), $urandom % 2, ra, rb, 5'($urandom));
    end
    // R11 reset mid-run clears flags
    step("R11", 1, 2, 0, 32'h1, 32'h0, 0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R11", "reset flags", flags_o, 4'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule